// File: doc/BRIEF.md
# Microcoded CPU Control Sequencer

This block sequences a small microcoded processor. A 4-bit step counter walks through up to sixteen microsteps per instruction. For each step it reads a 32-bit control word from a built-in microcode table. The table is addressed by the status flags, the current instruction code and the step number. The surrounding datapath (register file, ALU, memory and program counter) reads the control word and the strobes taken from it. A decoder turns the word's bus-source field into one-hot drive enables for the shared data bus.

The counter moves on the falling clock edge, so a new control word settles during the low phase. The destination registers then capture the bus on the next rising edge. Drive enables are only asserted while the clock is high, so the bus is released at the start of every low phase before the next source is selected. Every instruction starts with the same two fetch steps. Steps an instruction does not use hold a word that sends the counter back to step 0. The table implements four load-immediate instructions, a register add and a no-op.

Top module: `ucseq_top`

## Requirements
- R1: A synchronous active-high reset, sampled on the falling edge, clears the step counter. While reset is held and after it is released, the next high phase shows the step-0 word 0x0400_2000.
- R2: For every instruction code, step 0 gives 0x0400_2000 (program counter to bus, address-low load at bit 13). Step 1 gives 0x27E0_0001 (RAM to bus, instruction load at bit 29, PC increment at bit 0).
- R3: Without reset, the step counter advances by one on each falling edge when neither bit 30 nor bit 31 of the current word is set. Bit 31 alone forces it to 8.
- R4: A step not used by the instruction gives 0x4000_0000 (bit 30 only). The following step is the step-0 fetch word, so a load-immediate repeats with a period of five steps.
- R5: Codes 0x000 to 0x003 load targets A, B, C and D. Step 2 gives 0x0400_2000. Step 3 gives 0x07E0_0001 plus the target's low-load bit: 5 for A, 7 for B, 9 for C, 11 for D.
- R6: Code 0x100 (add) gives 0x0780_0000 at step 2 (ALU-evaluate source) and 0x07A0_0020 at step 3 (ALU output to bus, A low load). Step 4 returns.
- R7: Code 0x3FF and any code not in the table use the shared fetch, then give 0x4000_0000 from step 2 on.
- R8: The flags form address bits 15 (zero) and 14 (carry), above the code in bits 13:4 and the step in bits 3:0. The current table gives the same words for every flag value.
- R9: With bit 26 set, field 25:21 selects one enable bit: code 0 sets bit 0 (PC), 1 sets bit 1 (SP), 0b01010 sets bit 2, 0b11100 sets bit 3 (ALU evaluate), 0b11101 sets bit 4 (ALU output), 0b11111 sets bit 5 (RAM). When bit 26 is clear or the code is undefined, no enable is set.
- R10: All drive enables are low while the clock is low.
- R11: Each strobe follows its control bit: pc_inc 0, pc_load 1, sp_down 2, sp_clk 3, sp_load 4, reg_load 12:5, addr_load 14:13, ram_wr 28, ir_load 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; falling edge advances the step |
| rst | input | 1 | Synchronous active-high reset |
| ir_i | input | 10 | Current instruction code |
| carry_i | input | 1 | Carry status flag |
| zero_i | input | 1 | Zero status flag |
| ctrl_o | output | 32 | Current control word |
| oe_o | output | 6 | One-hot bus drive enables, high phase only |
| pc_inc_o | output | 1 | Program counter increment |
| pc_load_o | output | 1 | Program counter load |
| sp_clk_o | output | 1 | Stack pointer count |
| sp_down_o | output | 1 | Stack pointer count direction down |
| sp_load_o | output | 1 | Stack pointer load |
| reg_load_o | output | 8 | Low/high byte loads of registers A to D |
| addr_load_o | output | 2 | Memory address low/high loads |
| ir_load_o | output | 1 | Instruction register load |
| ram_wr_o | output | 1 | RAM write |

## Verification
A step counter that skips, sticks or fails to return shows up in the very next high phase as a control word from the wrong step. For example, a fetch word appears where an execute word should be, or a return word is followed by something other than the fetch word. So the table walk checks chosen steps up to nine falling edges after reset. A wrong source decode or a missing low-phase gate shows at once on the enables, with the wrong bit or more than one bit high. The strobes are compared against the word in the same phase.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int CW      = 32;
  localparam int STEP_W  = 4;
  localparam int OP_W    = 10;
  localparam int FLAG_W  = 2;
  localparam int ADDR_W  = FLAG_W + OP_W + STEP_W;
  localparam int SRC_W   = 5;
  localparam int N_SRC   = 6;
  localparam int N_REGLD = 8;

  // control word bit positions
  localparam int B_PC_INC  = 0;
  localparam int B_PC_LD   = 1;
  localparam int B_SP_DN   = 2;
  localparam int B_SP_CLK  = 3;
  localparam int B_SP_LD   = 4;
  localparam int B_REG_LD0 = 5;
  localparam int B_ADR_LD0 = 13;
  localparam int B_SRC_LSB = 21;
  localparam int B_SRC_EN  = 26;
  localparam int B_RAM_WR  = 28;
  localparam int B_IR_LD   = 29;
  localparam int B_TO_ZERO = 30;
  localparam int B_TO_HALF = 31;

  localparam logic [OP_W-1:0] OP_ADD = 10'h100;

  // bus source codes, index order = enable bit order
  function automatic logic [SRC_W-1:0] src_code(input int idx);
    case (idx)
      0:       return 5'b00000; // program counter
      1:       return 5'b00001; // stack pointer
      2:       return 5'b01010; // AB pair
      3:       return 5'b11100; // ALU evaluate
      4:       return 5'b11101; // ALU output
      default: return 5'b11111; // RAM
    endcase
  endfunction

  function automatic logic [CW-1:0] src_word(input int idx);
    return (CW'(1) << B_SRC_EN) | (CW'(src_code(idx)) << B_SRC_LSB);
  endfunction

  function automatic logic [CW-1:0] bit_word(input int pos);
    return CW'(1) << pos;
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input logic zero, input logic carry,
                                                input logic [OP_W-1:0] op,
                                                input logic [STEP_W-1:0] step);
    return {zero, carry, op, step};
  endfunction

  function automatic logic [STEP_W-1:0] next_step(input logic [STEP_W-1:0] step,
                                                  input logic [CW-1:0] word);
    if (word[B_TO_ZERO])      return '0;
    else if (word[B_TO_HALF]) return STEP_W'(1) << (STEP_W - 1);
    else                      return step + STEP_W'(1);
  endfunction

  localparam logic [CW-1:0] W_RETURN   = bit_word(B_TO_ZERO);
  localparam logic [CW-1:0] W_PC_MAR   = src_word(0) | bit_word(B_ADR_LD0);
  localparam logic [CW-1:0] W_FETCH_IR = src_word(5) | bit_word(B_IR_LD) | bit_word(B_PC_INC);
  localparam logic [CW-1:0] W_LD_BASE  = src_word(5) | bit_word(B_PC_INC);
  localparam logic [CW-1:0] W_ADD_EVAL = src_word(3);
  localparam logic [CW-1:0] W_ADD_OUT  = src_word(4) | bit_word(B_REG_LD0);
endpackage

// File: rtl/ucseq_step_ctr.sv
module ucseq_step_ctr
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     word,
  output logic [STEP_W-1:0] step
);
  // advances in the low phase so the new word settles before the rising edge
  always_ff @(negedge clk) begin
    if (rst) step <= '0;
    else     step <= next_step(step, word);
  end
endmodule

// File: rtl/ucseq_rom.sv
module ucseq_rom
  import ucseq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [CW-1:0]     word
);
  logic [1:0] ld_sel;
  assign ld_sel = addr[STEP_W +: 2];

  always_comb begin
    casez (addr)
      {2'b??, 10'b??????????, 4'd0}: word = W_PC_MAR;
      {2'b??, 10'b??????????, 4'd1}: word = W_FETCH_IR;
      {2'b??, 8'h00, 2'b??, 4'd2}:   word = W_PC_MAR;
      {2'b??, 8'h00, 2'b??, 4'd3}:   word = W_LD_BASE | bit_word(B_REG_LD0 + 2 * int'(ld_sel));
      {2'b??, OP_ADD, 4'd2}:         word = W_ADD_EVAL;
      {2'b??, OP_ADD, 4'd3}:         word = W_ADD_OUT;
      default:                       word = W_RETURN;
    endcase
  end
endmodule

// File: rtl/ucseq_src_dec.sv
module ucseq_src_dec
  import ucseq_pkg::*;
(
  input  logic             en,
  input  logic [SRC_W-1:0] code,
  output logic [N_SRC-1:0] sel
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign sel[g] = en && (code == src_code(g));
  end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
  import ucseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    ir_i,
  input  logic               carry_i,
  input  logic               zero_i,
  output logic [CW-1:0]      ctrl_o,
  output logic [N_SRC-1:0]   oe_o,
  output logic               pc_inc_o,
  output logic               pc_load_o,
  output logic               sp_clk_o,
  output logic               sp_down_o,
  output logic               sp_load_o,
  output logic [N_REGLD-1:0] reg_load_o,
  output logic [1:0]         addr_load_o,
  output logic               ir_load_o,
  output logic               ram_wr_o
);
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] rom_addr;
  logic [N_SRC-1:0]  src_sel;
  logic              drive_phase;

  assign rom_addr    = mk_addr(zero_i, carry_i, ir_i, step_q);
  assign drive_phase = clk;

  ucseq_step_ctr u_ctr (.clk(clk), .rst(rst), .word(ctrl_o), .step(step_q));
  ucseq_rom      u_rom (.addr(rom_addr), .word(ctrl_o));
  ucseq_src_dec  u_dec (.en(ctrl_o[B_SRC_EN]), .code(ctrl_o[B_SRC_LSB +: SRC_W]), .sel(src_sel));

  // bus released whenever the clock is low
  assign oe_o        = drive_phase ? src_sel : '0;
  assign pc_inc_o    = ctrl_o[B_PC_INC];
  assign pc_load_o   = ctrl_o[B_PC_LD];
  assign sp_clk_o    = ctrl_o[B_SP_CLK];
  assign sp_down_o   = ctrl_o[B_SP_DN];
  assign sp_load_o   = ctrl_o[B_SP_LD];
  assign reg_load_o  = ctrl_o[B_REG_LD0 +: N_REGLD];
  assign addr_load_o = ctrl_o[B_ADR_LD0 +: 2];
  assign ir_load_o   = ctrl_o[B_IR_LD];
  assign ram_wr_o    = ctrl_o[B_RAM_WR];
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk
  import ucseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic [CW-1:0]     ctrl,
  input logic [N_SRC-1:0]  oe
);
  a_r1_reset_clears: assert property (@(negedge clk) rst |=> step == '0);

  a_r3_step_advance: assert property (@(negedge clk) disable iff (rst)
    (!ctrl[B_TO_ZERO] && !ctrl[B_TO_HALF]) |=> step == STEP_W'($past(step) + 1'b1));

  a_r3_force_half: assert property (@(negedge clk) disable iff (rst)
    (ctrl[B_TO_HALF] && !ctrl[B_TO_ZERO]) |=> step == (STEP_W'(1) << (STEP_W - 1)));

  a_r4_return_fetch: assert property (@(negedge clk) disable iff (rst)
    ctrl[B_TO_ZERO] |=> step == '0);

  a_r9_onehot_oe: assert property (@(negedge clk) disable iff (rst) $onehot0(oe));

  a_r9_no_enable: assert property (@(negedge clk) disable iff (rst)
    !ctrl[B_SRC_EN] |-> oe == '0);

  a_r10_low_quiet: assert property (@(posedge clk) oe == '0);
endmodule

bind ucseq_top ucseq_chk u_chk (
  .clk(clk), .rst(rst), .step(step_q), .ctrl(ctrl_o), .oe(oe_o)
);

// File: tb/ucseq_top_tb.sv
module ucseq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [9:0]  ir = '0;
  logic        carry = 1'b0, zero = 1'b0;
  logic [31:0] ctrl;
  logic [5:0]  oe;
  logic        pc_inc, pc_load, sp_clk, sp_down, sp_load, ir_load, ram_wr;
  logic [7:0]  reg_load;
  logic [1:0]  addr_load;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ucseq_top u_dut (
    .clk(clk), .rst(rst), .ir_i(ir), .carry_i(carry), .zero_i(zero),
    .ctrl_o(ctrl), .oe_o(oe), .pc_inc_o(pc_inc), .pc_load_o(pc_load),
    .sp_clk_o(sp_clk), .sp_down_o(sp_down), .sp_load_o(sp_load),
    .reg_load_o(reg_load), .addr_load_o(addr_load), .ir_load_o(ir_load),
    .ram_wr_o(ram_wr)
  );

  // {flags(zero,carry), code, step, expected word}
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {2'b00, 10'h000, 4'd0, 32'h0400_2000},  // R2
    {2'b00, 10'h000, 4'd1, 32'h27E0_0001},  // R2
    {2'b00, 10'h000, 4'd2, 32'h0400_2000},  // R5
    {2'b00, 10'h000, 4'd3, 32'h07E0_0021},  // R5 A
    {2'b00, 10'h000, 4'd4, 32'h4000_0000},  // R4
    {2'b00, 10'h000, 4'd5, 32'h0400_2000},  // R4 back to fetch
    {2'b00, 10'h000, 4'd7, 32'h0400_2000},  // R3 period five
    {2'b00, 10'h000, 4'd9, 32'h4000_0000},  // R3
    {2'b00, 10'h001, 4'd3, 32'h07E0_0081},  // R5 B
    {2'b00, 10'h002, 4'd3, 32'h07E0_0201},  // R5 C
    {2'b00, 10'h003, 4'd3, 32'h07E0_0801},  // R5 D
    {2'b11, 10'h001, 4'd3, 32'h07E0_0081},  // R8 flags set
    {2'b00, 10'h100, 4'd2, 32'h0780_0000},  // R6
    {2'b00, 10'h100, 4'd3, 32'h07A0_0020},  // R6
    {2'b10, 10'h100, 4'd3, 32'h07A0_0020},  // R8
    {2'b00, 10'h100, 4'd4, 32'h4000_0000},  // R6 return
    {2'b00, 10'h3FF, 4'd1, 32'h27E0_0001},  // R7
    {2'b00, 10'h3FF, 4'd2, 32'h4000_0000},  // R7
    {2'b00, 10'h3FF, 4'd3, 32'h0400_2000},  // R7 refetch
    {2'b01, 10'h155, 4'd0, 32'h0400_2000},  // R7 unknown code
    {2'b00, 10'h155, 4'd2, 32'h4000_0000}   // R7 unknown code
  };

  function automatic logic [5:0] exp_oe(input logic [31:0] w);
    if (!w[26]) return 6'b0;
    if (w[25:21] == 5'd0)     return 6'b000001;
    if (w[25:21] == 5'd1)     return 6'b000010;
    if (w[25:21] == 5'd10)    return 6'b000100;
    if (w[25:21] == 5'd28)    return 6'b001000;
    if (w[25:21] == 5'd29)    return 6'b010000;
    if (w[25:21] == 5'd31)    return 6'b100000;
    return 6'b0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] fl, input logic [9:0] code);
    @(posedge clk); #1;
    rst = 1'b1; {zero, carry} = fl; ir = code;
    @(negedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    // R1: held reset shows the fetch word
    @(posedge clk); #1; rst = 1'b1; ir = 10'h100;
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    chk("R1 held", 64'(ctrl), 64'h0400_2000);
    @(negedge clk); #1; rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 released", 64'(ctrl), 64'h0400_2000);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      w = VEC[i][31:0];
      start(VEC[i][47:46], VEC[i][45:36]);
      repeat (int'(VEC[i][35:32])) @(negedge clk);
      @(posedge clk); #1;
      chk("R2-table word", 64'(ctrl), 64'(w));
      chk("R9", 64'(oe), 64'(exp_oe(w)));
      chk("R11", 64'({pc_inc, pc_load, sp_down, sp_clk, sp_load, reg_load, addr_load, ram_wr, ir_load}),
                 64'({w[0], w[1], w[2], w[3], w[4], w[12:5], w[14:13], w[28], w[29]}));
      @(negedge clk); #1;
      chk("R10", 64'(oe), 64'h0);
    end

    // R1: reset in mid instruction returns to fetch
    start(2'b00, 10'h002);
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    chk("R5 before reset", 64'(ctrl), 64'h07E0_0201);
    rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 mid-instruction", 64'(ctrl), 64'h0400_2000);
    chk("R9 pc source", 64'(oe), 64'h01);

    // R9: return word has enable clear, no drive
    start(2'b00, 10'h3FF);
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    chk("R9 disabled", 64'(oe), 64'h0);

    finish_run();
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule